// File: doc/BRIEF.md
# HDLC Channel Event Latch and Interrupt Mask

This block collects the events of one HDLC serial channel into a sticky 16-bit event register. A 16-bit mask register with the same bit layout decides which latched events may raise the channel's interrupt request. Some events arrive as one-cycle pulses from the framing engine, the clock-glitch detectors and the buffer handling. Others come from real-time status levels: line idle, flag reception and DPLL carrier sense. Each level passes through a two-flop synchronizer, and any change in either direction latches its event. Software reads both registers through a small synchronous port. It clears events by writing ones, and writing zeros leaves them untouched.

A small graceful-stop tracker also lives inside the block. It has two named states: `GS_IDLE` (no stop pending) and `GS_DRAIN` (waiting for the current transmit frame to end). On a stop command in `GS_IDLE` with no frame in flight, it sets the graceful-stop-complete event at once and stays in `GS_IDLE`. On a stop command in `GS_IDLE` with a frame in flight, it takes transition `GS_IDLE -> GS_DRAIN`. In `GS_DRAIN` it ignores further commands. When the frame-active level drops, it sets the event and takes transition `GS_DRAIN -> GS_IDLE`.

Bit positions below count from bit 0 as the least significant bit. Read as a 16-bit hex word, the writable set of bits is 0x1F9F.

Top module: `hdlc_evt_irq`

## Requirements
- R1: After reset, the event register and the mask register both read 0x0000, and `irq` is 0.
- R2: Each pulse input sets its event bit at the next rising clock edge. The positions are: rx-buffer bit 0, tx-buffer bit 1, busy bit 2, rx-frame bit 3, transmit error bit 4, rx-clock glitch bit 12, tx-clock glitch bit 11. Bit 4 sets on either `cts_lost_p` or `tx_underrun_p`. A set bit stays set until it is cleared.
- R3: A write with `reg_sel`=0 clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit remains set.
- R5: A write with `reg_sel`=1 stores the mask, and the mask reads back unchanged. Reserved bits 15:13 and 6:5 read as 0 in both registers and ignore writes.
- R6: `irq` is a register. One cycle after any event bit with its mask bit set reads 1, `irq` is 1. It stays 1 until every such bit is cleared, and it falls one cycle after that.
- R7: A change in either direction of `flag_lvl` sets bit 9, and a change of `idle_lvl` sets bit 8. Each bit is visible at the third rising edge after the level changes, and not before.
- R8: A change of `carrier_lvl` sets bit 10 only while `dpll_en` is 1. With `dpll_en` at 0, the change has no effect.
- R9: A `gs_cmd_p` pulse while `tx_frame_active` is 0 sets bit 7 at the same edge.
- R10: A `gs_cmd_p` pulse while `tx_frame_active` is 1 does not set bit 7 while the frame continues. Bit 7 sets at the first edge where `tx_frame_active` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| rx_glitch_p | input | 1 | Receive clock glitch pulse |
| tx_glitch_p | input | 1 | Transmit clock glitch pulse |
| cts_lost_p | input | 1 | CTS lost pulse |
| tx_underrun_p | input | 1 | Transmit underrun pulse |
| rx_frame_p | input | 1 | Receive frame complete pulse |
| busy_p | input | 1 | Receive busy pulse |
| tx_buf_p | input | 1 | Transmit buffer done pulse |
| rx_buf_p | input | 1 | Receive buffer done pulse |
| carrier_lvl | input | 1 | Asynchronous DPLL carrier-sense level |
| flag_lvl | input | 1 | Asynchronous flag-reception level |
| idle_lvl | input | 1 | Asynchronous line-idle level |
| dpll_en | input | 1 | DPLL in use; enables carrier events |
| gs_cmd_p | input | 1 | Graceful-stop command pulse |
| tx_frame_active | input | 1 | High while a transmit frame is in flight |
| irq | output | 1 | Level interrupt request |

## Verification
Each result has its own due cycle:

- Pulse events and the graceful-stop event are due at the edge that samples their cause.
- `irq` is due one edge after the event or mask that causes it, and it falls one edge after the last enabling bit is cleared.
- Level-change events are due at the third edge, because the synchronizer adds two flops and the edge detector adds a third.

The bench drives every input just after a falling edge and reads just before the next falling edge. In each check it counts exactly the edges in between. For the level events it also reads one edge early, to confirm the bit is not yet set.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;
    localparam int EVT_W   = 16;
    localparam int B_RXBUF = 0;
    localparam int B_TXBUF = 1;
    localparam int B_BUSY  = 2;
    localparam int B_RXFRM = 3;
    localparam int B_TXERR = 4;
    localparam int B_GSTOP = 7;
    localparam int B_IDLE  = 8;
    localparam int B_FLAG  = 9;
    localparam int B_CARR  = 10;
    localparam int B_TXGL  = 11;
    localparam int B_RXGL  = 12;
    localparam logic [EVT_W-1:0] EVT_VALID = 16'h1F9F;

    typedef enum logic [0:0] {
        GS_IDLE  = 1'b0,
        GS_DRAIN = 1'b1
    } gs_state_e;
endpackage

// File: rtl/hdlc_lvl_edge.sv
module hdlc_lvl_edge #(
    parameter int N_LINES = 3,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lvl_in,
    output logic [N_LINES-1:0] chg_o
);
    localparam int SH_W = STAGES + 1;

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            logic [SH_W-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[SH_W-2:0], lvl_in[i]};
            end
            assign chg_o[i] = sh_q[SH_W-1] ^ sh_q[SH_W-2];
        end
    endgenerate
endmodule

// File: rtl/hdlc_gstop_fsm.sv
module hdlc_gstop_fsm
    import hdlc_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_p,
    input  logic frame_active,
    output logic done_p
);
    gs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        done_p  = 1'b0;
        unique case (state_q)
            GS_IDLE: begin
                if (cmd_p) begin
                    if (frame_active) state_d = GS_DRAIN;
                    else              done_p  = 1'b1;
                end
            end
            GS_DRAIN: begin
                if (!frame_active) begin
                    done_p  = 1'b1;
                    state_d = GS_IDLE;
                end
            end
        endcase
    end

    AST_GS_ENTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_IDLE && cmd_p && frame_active) |=> (state_q == GS_DRAIN && !done_p) || !frame_active); // R10
    AST_GS_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_DRAIN && frame_active) |-> !done_p); // R10
    AST_GS_DONE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> state_q == GS_IDLE); // R9
endmodule

// File: rtl/hdlc_evt_regs.sv
module hdlc_evt_regs
    import hdlc_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] hw_set,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [EVT_W-1:0] wr_data,
    output logic [EVT_W-1:0] rd_data,
    output logic             irq_o
);
    logic [EVT_W-1:0] evt_q, evt_d, msk_q, msk_d, clr_v;
    logic             irq_q;

    always_comb begin
        clr_v = (wr_en && !sel) ? wr_data : '0;
        evt_d = ((evt_q & ~clr_v) | hw_set) & EVT_VALID;
        msk_d = (wr_en && sel) ? (wr_data & EVT_VALID) : msk_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            msk_q <= '0;
            irq_q <= 1'b0;
        end else begin
            evt_q <= evt_d;
            msk_q <= msk_d;
            irq_q <= |(evt_q & msk_q);
        end
    end

    assign rd_data = sel ? msk_q : evt_q;
    assign irq_o   = irq_q;

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q | msk_q) & ~EVT_VALID) == '0); // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & EVT_VALID)) |=> (evt_q & $past(hw_set & EVT_VALID)) == $past(hw_set & EVT_VALID)); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel && hw_set == '0) |=> (evt_q & $past(wr_data)) == '0); // R3
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == |($past(evt_q) & $past(msk_q))); // R6
endmodule

// File: rtl/hdlc_evt_irq.sv
module hdlc_evt_irq
    import hdlc_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        rx_glitch_p,
    input  logic        tx_glitch_p,
    input  logic        cts_lost_p,
    input  logic        tx_underrun_p,
    input  logic        rx_frame_p,
    input  logic        busy_p,
    input  logic        tx_buf_p,
    input  logic        rx_buf_p,
    input  logic        carrier_lvl,
    input  logic        flag_lvl,
    input  logic        idle_lvl,
    input  logic        dpll_en,
    input  logic        gs_cmd_p,
    input  logic        tx_frame_active,
    output logic        irq
);
    localparam int N_LVL = 3;

    logic [N_LVL-1:0] lvl_chg;
    logic             gs_done;
    logic [EVT_W-1:0] hw_set;

    hdlc_lvl_edge #(.N_LINES(N_LVL), .STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in ({carrier_lvl, flag_lvl, idle_lvl}),
        .chg_o  (lvl_chg)
    );

    hdlc_gstop_fsm u_gs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_p        (gs_cmd_p),
        .frame_active (tx_frame_active),
        .done_p       (gs_done)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[B_RXBUF] = rx_buf_p;
        hw_set[B_TXBUF] = tx_buf_p;
        hw_set[B_BUSY]  = busy_p;
        hw_set[B_RXFRM] = rx_frame_p;
        hw_set[B_TXERR] = cts_lost_p | tx_underrun_p;
        hw_set[B_GSTOP] = gs_done;
        hw_set[B_IDLE]  = lvl_chg[0];
        hw_set[B_FLAG]  = lvl_chg[1];
        hw_set[B_CARR]  = lvl_chg[2] & dpll_en;
        hw_set[B_TXGL]  = tx_glitch_p;
        hw_set[B_RXGL]  = rx_glitch_p;
    end

    hdlc_evt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .wr_en   (reg_wr),
        .sel     (reg_sel),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .irq_o   (irq)
    );

    AST_CARR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !dpll_en |-> !hw_set[B_CARR]); // R8
    AST_TXERR_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_lost_p || tx_underrun_p) |=> reg_sel || reg_rdata[B_TXERR] || $past(reg_wr)); // R2
endmodule

// File: tb/hdlc_evt_irq_test.sv
module hdlc_evt_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  pul = '0;
    logic        carrier_lvl = 1'b0, flag_lvl = 1'b0, idle_lvl = 1'b0, dpll_en = 1'b0;
    logic        gs_cmd_p = 1'b0, tx_frame_active = 1'b0;
    logic        irq;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    hdlc_evt_irq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_glitch_p(pul[0]), .tx_glitch_p(pul[1]), .cts_lost_p(pul[2]),
        .tx_underrun_p(pul[3]), .rx_frame_p(pul[4]), .busy_p(pul[5]),
        .tx_buf_p(pul[6]), .rx_buf_p(pul[7]),
        .carrier_lvl(carrier_lvl), .flag_lvl(flag_lvl), .idle_lvl(idle_lvl),
        .dpll_en(dpll_en), .gs_cmd_p(gs_cmd_p), .tx_frame_active(tx_frame_active),
        .irq(irq)
    );

    typedef struct packed { logic [7:0] p; logic [15:0] e; } vec_t;
    localparam vec_t VEC [10] = '{
        '{8'h01, 16'h1000}, '{8'h02, 16'h0800}, '{8'h04, 16'h0010},
        '{8'h08, 16'h0010}, '{8'h0C, 16'h0010}, '{8'h10, 16'h0008},
        '{8'h20, 16'h0004}, '{8'h40, 16'h0002}, '{8'h80, 16'h0001},
        '{8'hFF, 16'h181F}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        reg_sel = sel; #1 d = reg_rdata; reg_sel = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] p);
        pul = p; tick(); pul = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(1'b0, v); check("R1 event", v, 16'h0000);
        rd(1'b1, v); check("R1 mask", v, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);

        // R2 table walk
        for (int i = 0; i < 10; i++) begin
            wr(1'b0, 16'hFFFF);
            pulse(VEC[i].p);
            rd(1'b0, v); check($sformatf("R2 vec%0d", i), v, VEC[i].e);
            tick(2);
            rd(1'b0, v); check($sformatf("R2 sticky vec%0d", i), v, VEC[i].e);
        end
        wr(1'b0, 16'hFFFF);

        // R5 mask and reserved bits
        wr(1'b1, 16'hFFFF);
        rd(1'b1, v); check("R5 mask reserved", v, 16'h1F9F);
        wr(1'b1, 16'h0A05);
        rd(1'b1, v); check("R5 mask readback", v, 16'h0A05);
        wr(1'b1, 16'h0000);

        // R3 write-one-to-clear
        pulse(8'hA0);
        rd(1'b0, v); check("R3 setup", v, 16'h0005);
        wr(1'b0, 16'h0001);
        rd(1'b0, v); check("R3 clear one", v, 16'h0004);
        wr(1'b0, 16'h0000);
        rd(1'b0, v); check("R3 zero no effect", v, 16'h0004);

        // R6 interrupt
        wr(1'b1, 16'h0004);
        tick();
        check("R6 irq rises", {15'b0, irq}, 16'h0001);
        pulse(8'h80);
        wr(1'b0, 16'h0004);
        tick();
        check("R6 irq falls masked only", {15'b0, irq}, 16'h0000);
        wr(1'b1, 16'h0005);
        pulse(8'h20);
        tick();
        check("R6 irq both", {15'b0, irq}, 16'h0001);
        wr(1'b0, 16'h0001);
        tick();
        check("R6 irq holds", {15'b0, irq}, 16'h0001);
        wr(1'b0, 16'h0004);
        tick();
        check("R6 irq cleared", {15'b0, irq}, 16'h0000);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'hFFFF);

        // R4 collision
        pul = 8'h80; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0001;
        tick();
        pul = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(1'b0, v); check("R4 event wins", v, 16'h0001);
        wr(1'b0, 16'hFFFF);

        // R7 flag and idle both edges
        flag_lvl = 1'b1;
        tick(2); rd(1'b0, v); check("R7 flag early", v, 16'h0000);
        tick();  rd(1'b0, v); check("R7 flag rise", v, 16'h0200);
        wr(1'b0, 16'hFFFF);
        flag_lvl = 1'b0;
        tick(3); rd(1'b0, v); check("R7 flag fall", v, 16'h0200);
        wr(1'b0, 16'hFFFF);
        idle_lvl = 1'b1;
        tick(3); rd(1'b0, v); check("R7 idle rise", v, 16'h0100);
        wr(1'b0, 16'hFFFF);
        idle_lvl = 1'b0;
        tick(3); rd(1'b0, v); check("R7 idle fall", v, 16'h0100);
        wr(1'b0, 16'hFFFF);

        // R8 carrier gated
        carrier_lvl = 1'b1;
        tick(5); rd(1'b0, v); check("R8 carrier gated", v, 16'h0000);
        dpll_en = 1'b1;
        carrier_lvl = 1'b0;
        tick(3); rd(1'b0, v); check("R8 carrier enabled", v, 16'h0400);
        wr(1'b0, 16'hFFFF);

        // R9 immediate graceful stop
        gs_cmd_p = 1'b1; tick(); gs_cmd_p = 1'b0;
        rd(1'b0, v); check("R9 immediate", v, 16'h0080);
        wr(1'b0, 16'hFFFF);

        // R10 deferred graceful stop
        tx_frame_active = 1'b1;
        gs_cmd_p = 1'b1; tick(); gs_cmd_p = 1'b0;
        tick(4);
        rd(1'b0, v); check("R10 pending", v, 16'h0000);
        tx_frame_active = 1'b0;
        tick();
        rd(1'b0, v); check("R10 done", v, 16'h0080);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule